// File: doc/BRIEF.md
# Split-Word 64-bit Register Bridge

This block sits between a 32-bit register bus and a set of 64-bit quantities. Some of them are writable configuration registers and some are free-running event counters. Each 64-bit entry takes two neighbouring word addresses. A parameter decides which of the two words carries bits 63..32.

Writes are two-phase. The word at the lower address is only parked in a staging register. The whole 64-bit value is written only when the word at the higher address arrives. Reads are made coherent by a snapshot. The first read of an entry returns its live half and freezes the partner half. The read that follows then returns the frozen partner, so a counter that moves between the two bus reads still yields one consistent 64-bit value.

Bit 31 of entry 0 is a self-clearing command bit. Committing a one there produces a single-cycle pulse, and the bit is never stored.

Top module: `split_word_bridge`

## Requirements
- R1: A synchronous active-high reset clears every register, every counter, the staging word and the read snapshot. After reset `rsp_valid`, `ctl_pulse` and `regs_q` are all zero.
- R2: The address is decoded as follows.
  - `req_addr[0]` selects the half: 0 is the lower address and 1 is the higher address.
  - `req_addr[AW-1:1]` is the entry index.
  - Entries 0..NUM_REGS-1 are registers.
  - Entries NUM_REGS..NUM_REGS+NUM_CNTS-1 are counters, with counter c at entry NUM_REGS+c.
- R3: The parameter `UPPER_FIRST` sets the word order for both reads and writes. When it is 1, the lower address holds bits 63..32 and the higher address holds bits 31..0. When it is 0, the lower address holds bits 31..0 and the higher address holds bits 63..32.
- R4: A write to the lower address of a register loads the staging word only. `regs_q` does not change.
- R5: A write to the higher address of register k writes the staging word and the write data into k together, placed according to R3. The new value shows on `regs_q[64k+63:64k]` one cycle later. The staging word keeps its value after the commit. If the higher address is written with no lower-address write before it, the value staged earlier (zero after reset) is used.
- R6: When a commit to entry 0 carries a one in bit 31, `ctl_pulse` is high for exactly the next cycle. Bit 31 of entry 0 always reads and stays 0. For any other commit `ctl_pulse` stays low.
- R7: Counter c increases by one on every clock in which `evt_inc[c]` is high. Writes to counter addresses change neither the counters nor the staging word.
- R8: An accepted read is answered on the next cycle with `rsp_valid` high. `rsp_valid` is low in every other cycle. A read of an address past the last entry returns 0 and leaves the snapshot untouched. `req_ready` is always high.
- R9: A first read of an entry returns the live half and captures the partner half. The next read of that partner half returns the captured value, even if the entry changed in between, and releases the snapshot. The read after that returns live data.
- R10: While a snapshot is pending, a read of the same half of the same entry returns live data and keeps the snapshot. A read of a different entry discards the old snapshot and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address (entry index and half select) |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always high) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| evt_inc | input | NUM_CNTS | Per-counter increment strobes |
| regs_q | output | 64*NUM_REGS | Committed register values, entry k at bits 64k+63..64k |
| ctl_pulse | output | 1 | One-cycle pulse from the self-clearing bit |

## Verification
The properties assume that no request is presented while reset is high or in the cycle it is released. They also assume that a request is either a read or a write and never both.

The bench drives every request one clock after an edge and holds `req_valid` low throughout each reset. Because of this, stability and response-timing checks never straddle a reset boundary. The event strobes are changed only between edges, so each one counts for whole cycles.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int WORD_W      = 32;
    localparam int DWORD_W     = 64;
    localparam int SELFCLR_BIT = 31;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [DWORD_W-1:0] dword_t;

    // decoded bus operation for one cycle
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_STAGE  = 2'd1,
        OP_COMMIT = 2'd2,
        OP_READ   = 2'd3
    } op_e;

    // read snapshot state
    typedef struct packed {
        logic  armed;
        logic  pend_hi;   // address half that will return the snapshot
        word_t data;
    } snap_t;

    // true when the given address half carries bits 63..32
    function automatic logic holds_upper(logic hi_addr, bit upper_first);
        return upper_first ? !hi_addr : hi_addr;
    endfunction

    function automatic word_t pick_word(dword_t v, logic hi_addr, bit upper_first);
        return holds_upper(hi_addr, upper_first) ? v[63:32] : v[31:0];
    endfunction

    function automatic dword_t join_words(word_t lo_word, word_t hi_word, bit upper_first);
        return upper_first ? {lo_word, hi_word} : {hi_word, lo_word};
    endfunction

endpackage

// File: rtl/swb_regbank.sv
module swb_regbank
    import swb_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter bit UPPER_FIRST = 1'b1,
    parameter int PW          = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  op_e                         op,
    input  logic [PW-1:0]               pair,
    input  word_t                       wdata,
    output logic [NUM_REGS*DWORD_W-1:0] regs_o,
    output logic                        pulse_o
);

    word_t  stage_q;
    dword_t merged;
    dword_t cleaned;
    logic   hits_ctl;

    always_comb begin
        merged   = join_words(stage_q, wdata, UPPER_FIRST);
        hits_ctl = (pair == '0);
        cleaned  = merged;
        if (hits_ctl) begin
            cleaned[SELFCLR_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (op == OP_STAGE) begin
            stage_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= (op == OP_COMMIT) && hits_ctl && merged[SELFCLR_BIT];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        dword_t val_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (op == OP_COMMIT && pair == PW'(g)) begin
                val_q <= cleaned;
            end
        end
        assign regs_o[g*DWORD_W +: DWORD_W] = val_q;
    end

endmodule

// File: rtl/swb_counters.sv
module swb_counters
    import swb_pkg::*;
#(
    parameter int NUM_CNTS = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CNTS-1:0]         evt,
    output logic [NUM_CNTS*DWORD_W-1:0] cnt_o
);

    for (genvar g = 0; g < NUM_CNTS; g++) begin : g_cnt
        dword_t c_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                c_q <= '0;
            end else begin
                c_q <= c_q + DWORD_W'(evt[g]);
            end
        end
        assign cnt_o[g*DWORD_W +: DWORD_W] = c_q;
    end

endmodule

// File: rtl/swb_readport.sv
module swb_readport
    import swb_pkg::*;
#(
    parameter int NUM_ENT     = 7,
    parameter bit UPPER_FIRST = 1'b1,
    parameter int PW          = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_en,
    input  logic                       in_range,
    input  logic                       hi_addr,
    input  logic [PW-1:0]              pair,
    input  logic [NUM_ENT*DWORD_W-1:0] live_i,
    output logic                       rsp_valid,
    output word_t                      rsp_rdata
);

    snap_t         snap_q;
    logic [PW-1:0] snap_pair_q;
    dword_t        cur;
    logic          same_pair;
    logic          partner_rd;

    always_comb begin
        cur = '0;
        for (int k = 0; k < NUM_ENT; k++) begin
            if (pair == PW'(k)) begin
                cur = live_i[k*DWORD_W +: DWORD_W];
            end
        end
        same_pair  = snap_q.armed && (snap_pair_q == pair);
        partner_rd = same_pair && (snap_q.pend_hi == hi_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            snap_q      <= '0;
            snap_pair_q <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                if (!in_range) begin
                    rsp_rdata <= '0;
                end else if (partner_rd) begin
                    rsp_rdata    <= snap_q.data;
                    snap_q.armed <= 1'b0;
                end else if (same_pair) begin
                    rsp_rdata <= pick_word(cur, hi_addr, UPPER_FIRST);
                end else begin
                    rsp_rdata   <= pick_word(cur, hi_addr, UPPER_FIRST);
                    snap_q      <= '{armed: 1'b1, pend_hi: !hi_addr,
                                     data: pick_word(cur, !hi_addr, UPPER_FIRST)};
                    snap_pair_q <= pair;
                end
            end
        end
    end

endmodule

// File: rtl/split_word_bridge.sv
module split_word_bridge
    import swb_pkg::*;
#(
    parameter  int NUM_REGS    = 4,
    parameter  int NUM_CNTS    = 3,
    parameter  bit UPPER_FIRST = 1'b1,
    localparam int NUM_ENT     = NUM_REGS + NUM_CNTS,
    localparam int AW          = $clog2(2 * NUM_ENT),
    localparam int PW          = AW - 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [AW-1:0]               req_addr,
    input  logic [WORD_W-1:0]           req_wdata,
    output logic                        req_ready,
    output logic                        rsp_valid,
    output logic [WORD_W-1:0]           rsp_rdata,
    input  logic [NUM_CNTS-1:0]         evt_inc,
    output logic [NUM_REGS*DWORD_W-1:0] regs_q,
    output logic                        ctl_pulse
);

    logic [PW-1:0]               pair;
    logic                        hi_addr;
    logic                        in_range;
    logic                        is_reg;
    logic                        accept;
    op_e                         op;
    logic [NUM_CNTS*DWORD_W-1:0] cnt_flat;
    logic [NUM_ENT*DWORD_W-1:0]  live_flat;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;
    assign pair      = req_addr[AW-1:1];
    assign hi_addr   = req_addr[0];
    assign in_range  = {1'b0, pair} < (PW+1)'(NUM_ENT);
    assign is_reg    = {1'b0, pair} < (PW+1)'(NUM_REGS);

    always_comb begin
        op = OP_IDLE;
        if (accept) begin
            if (req_write) begin
                if (is_reg) begin
                    op = hi_addr ? OP_COMMIT : OP_STAGE;
                end
            end else begin
                op = OP_READ;
            end
        end
    end

    swb_regbank #(
        .NUM_REGS    (NUM_REGS),
        .UPPER_FIRST (UPPER_FIRST),
        .PW          (PW)
    ) u_regbank (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .pair    (pair),
        .wdata   (req_wdata),
        .regs_o  (regs_q),
        .pulse_o (ctl_pulse)
    );

    swb_counters #(
        .NUM_CNTS (NUM_CNTS)
    ) u_counters (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_inc),
        .cnt_o (cnt_flat)
    );

    assign live_flat = {cnt_flat, regs_q};

    swb_readport #(
        .NUM_ENT     (NUM_ENT),
        .UPPER_FIRST (UPPER_FIRST),
        .PW          (PW)
    ) u_readport (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (op == OP_READ),
        .in_range  (in_range),
        .hi_addr   (hi_addr),
        .pair      (pair),
        .live_i    (live_flat),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/split_word_bridge_chk.sv
module split_word_bridge_chk
    import swb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int AW       = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [AW-1:0]               req_addr,
    input logic                        rsp_valid,
    input logic [NUM_REGS*DWORD_W-1:0] regs_q,
    input logic                        ctl_pulse
);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid); // R8

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid); // R8

    AST_STAGE_KEEPS_REGS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_addr[0]) |=> $stable(regs_q)); // R4

    AST_IDLE_KEEPS_REGS: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> $stable(regs_q)); // R5

    AST_PULSE_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        ctl_pulse |-> $past(req_valid && req_write && req_addr[0])); // R6

    AST_SELFCLR_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        regs_q[SELFCLR_BIT] == 1'b0); // R6

endmodule

bind split_word_bridge split_word_bridge_chk #(
    .NUM_REGS (NUM_REGS),
    .AW       (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .regs_q    (regs_q),
    .ctl_pulse (ctl_pulse)
);

// File: tb/split_word_bridge_tb.sv
module split_word_bridge_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NR = 4;
    localparam int NC = 3;
    localparam int AW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic [NC-1:0]   evt_inc = '0;
    logic            req_ready, rsp_valid, ctl_pulse;
    logic [31:0]     rsp_rdata;
    logic [NR*64-1:0] regs_q;
    logic            req_ready_s, rsp_valid_s, ctl_pulse_s;
    logic [31:0]     rsp_rdata_s;
    logic [NR*64-1:0] regs_q_s;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    split_word_bridge #(.NUM_REGS(NR), .NUM_CNTS(NC), .UPPER_FIRST(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_inc(evt_inc),
        .regs_q(regs_q), .ctl_pulse(ctl_pulse)
    );

    split_word_bridge #(.NUM_REGS(NR), .NUM_CNTS(NC), .UPPER_FIRST(1'b0)) u_dut_swap (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready_s),
        .rsp_valid(rsp_valid_s), .rsp_rdata(rsp_rdata_s), .evt_inc(evt_inc),
        .regs_q(regs_q_s), .ctl_pulse(ctl_pulse_s)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference of u_dut (upper half at the lower address)
    logic [63:0] m_reg [NR];
    logic [63:0] m_cnt [NC];
    logic [31:0] m_stage, m_shadow, m_rd;
    bit          m_armed, m_pend, m_rv, m_pulse;
    int          m_pair;

    always @(posedge clk) begin : model
        int          p;
        bit          h;
        logic [63:0] v;
        cyc++;
        if (rst) begin
            for (int i = 0; i < NR; i++) m_reg[i] = '0;
            for (int i = 0; i < NC; i++) m_cnt[i] = '0;
            m_stage = '0; m_shadow = '0; m_rd = '0;
            m_armed = 0; m_pend = 0; m_rv = 0; m_pulse = 0; m_pair = 0;
        end else begin
            m_rv = 0;
            m_pulse = 0;
            p = int'(req_addr[AW-1:1]);
            h = req_addr[0];
            if (req_valid && req_write && p < NR) begin
                if (!h) m_stage = req_wdata;
                else begin
                    v = {m_stage, req_wdata};
                    if (p == 0 && v[31]) begin
                        m_pulse = 1;
                        v[31] = 1'b0;
                    end
                    m_reg[p] = v;
                end
            end
            if (req_valid && !req_write) begin
                m_rv = 1;
                if (p >= NR + NC) m_rd = '0;
                else begin
                    v = (p < NR) ? m_reg[p] : m_cnt[p-NR];
                    if (m_armed && m_pair == p) begin
                        if (h == m_pend) begin
                            m_rd = m_shadow;
                            m_armed = 0;
                        end else m_rd = h ? v[31:0] : v[63:32];
                    end else begin
                        m_rd = h ? v[31:0] : v[63:32];
                        m_shadow = h ? v[63:32] : v[31:0];
                        m_armed = 1;
                        m_pair = p;
                        m_pend = !h;
                    end
                end
            end
            for (int i = 0; i < NC; i++) m_cnt[i] = m_cnt[i] + 64'(evt_inc[i]);
        end
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R8 watchdog act=%0d exp=<20000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && cyc > 1 && !done) begin
            for (int i = 0; i < NR; i++) chk("R5 regs_q vs model", regs_q[i*64 +: 64], m_reg[i]);
            chk("R8 rsp_valid vs model", 64'(rsp_valid), 64'(m_rv));
            if (m_rv) chk("R9 rsp_rdata vs model", 64'(rsp_rdata), 64'(m_rd));
            chk("R6 ctl_pulse vs model", 64'(ctl_pulse), 64'(m_pulse));
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d, output logic [31:0] ds);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        d = rsp_rdata;
        ds = rsp_rdata_s;
        @(posedge clk); #1;
    endtask

    initial begin
        logic [31:0] d, ds, a, as, b, bs;
        idle(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 regs_q after reset", 64'(regs_q == '0), 64'd1);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1 ctl_pulse after reset", 64'(ctl_pulse), 64'd0);
        rd(4'd3, d, ds);  chk("R1 read after reset", 64'(d), 64'd0);
        rd(4'd2, d, ds);  chk("R9 partner after reset", 64'(d), 64'd0);

        // R5 commit without staging uses zero stage
        wr(4'd3, 32'h1111_2222);
        chk("R5 high-only commit", regs_q[127:64], 64'h0000_0000_1111_2222);
        chk("R3 swapped high-only commit", regs_q_s[127:64], 64'h1111_2222_0000_0000);
        // R4 staging write leaves registers
        wr(4'd2, 32'hA5A5_0001);
        chk("R4 stage leaves reg", regs_q[127:64], 64'h0000_0000_1111_2222);
        wr(4'd3, 32'h0BAD_F00D);
        chk("R5 full commit", regs_q[127:64], 64'hA5A5_0001_0BAD_F00D);
        chk("R3 swapped full commit", regs_q_s[127:64], 64'h0BAD_F00D_A5A5_0001);
        // R5 stage retained across commits
        wr(4'd5, 32'h7777_0000);
        chk("R5 stage reuse", regs_q[191:128], 64'hA5A5_0001_7777_0000);

        // R2 / R3 reads
        rd(4'd2, d, ds);
        chk("R2 lower address read", 64'(d), 64'hA5A5_0001);
        chk("R3 swapped lower address read", 64'(ds), 64'hA5A5_0001);
        rd(4'd3, d, ds);
        chk("R2 higher address read", 64'(d), 64'h0BAD_F00D);
        chk("R3 swapped higher address read", 64'(ds), 64'h0BAD_F00D);

        // R9 snapshot survives an update
        rd(4'd4, d, ds);  chk("R9 first half", 64'(d), 64'hA5A5_0001);
        wr(4'd4, 32'h1234_5678);
        wr(4'd5, 32'h9ABC_DEF0);
        rd(4'd5, d, ds);  chk("R9 snapshot returned", 64'(d), 64'h7777_0000);
        rd(4'd5, d, ds);  chk("R9 released, live", 64'(d), 64'h9ABC_DEF0);

        // R10 same half twice keeps snapshot
        rd(4'd6, d, ds);  chk("R10 first half", 64'(d), 64'h0);
        wr(4'd6, 32'hCAFE_0000);
        wr(4'd7, 32'h0000_BEEF);
        rd(4'd6, d, ds);  chk("R10 repeat half live", 64'(d), 64'hCAFE_0000);
        rd(4'd7, d, ds);  chk("R10 snapshot kept", 64'(d), 64'h0);
        // R10 other entry replaces snapshot
        rd(4'd6, d, ds);  chk("R10 arm entry 3", 64'(d), 64'hCAFE_0000);
        rd(4'd4, d, ds);  chk("R10 arm entry 2", 64'(d), 64'h1234_5678);
        wr(4'd6, 32'h0);
        wr(4'd7, 32'h5555_AAAA);
        rd(4'd7, d, ds);  chk("R10 replaced, live", 64'(d), 64'h5555_AAAA);

        // R8 out of range
        rd(4'd4, d, ds);  chk("R8 arm before range test", 64'(d), 64'h1234_5678);
        rd(4'd14, d, ds); chk("R8 out of range reads 0", 64'(d), 64'h0);
        rd(4'd15, d, ds); chk("R8 out of range reads 0 hi", 64'(d), 64'h0);
        rd(4'd5, d, ds);  chk("R8 snapshot untouched", 64'(d), 64'h9ABC_DEF0);

        // R6 self-clearing bit
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h8000_0001);
        chk("R6 pulse high", 64'(ctl_pulse), 64'd1);
        chk("R6 swapped no pulse", 64'(ctl_pulse_s), 64'd0);
        chk("R6 bit not stored", regs_q[63:0], 64'h1);
        chk("R3 swapped entry 0", regs_q_s[63:0], 64'h8000_0001_0000_0000);
        idle(1);
        chk("R6 pulse one cycle", 64'(ctl_pulse), 64'd0);
        wr(4'd0, 32'h8000_0000);
        wr(4'd1, 32'h0);
        chk("R6 upper bit no pulse", 64'(ctl_pulse), 64'd0);
        chk("R6 swapped pulse", 64'(ctl_pulse_s), 64'd1);
        chk("R6 swapped bit not stored", regs_q_s[63:0], 64'h0);
        chk("R6 upper bit stored", regs_q[63:0], 64'h8000_0000_0000_0000);

        // R7 counters
        evt_inc = 3'b001;
        idle(3);
        rd(4'd9, a, as);  chk("R7 count after 3 cycles", 64'(a), 64'd3);
        rd(4'd9, b, bs);  chk("R7 count advances", 64'(b), 64'd5);
        rd(4'd8, d, ds);
        chk("R9 counter upper snapshot", 64'(d), 64'd0);
        chk("R3 swapped counter snapshot", 64'(ds), 64'(a));
        evt_inc = 3'b000;
        idle(1);
        rd(4'd9, a, as);
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0000_0001);
        rd(4'd9, b, bs);  chk("R7 counter write ignored", 64'(b), 64'(a));
        wr(4'd3, 32'h0);
        chk("R7 counter write leaves stage", regs_q[127:64], 64'h8000_0000_0000_0000);
        rd(4'd11, d, ds); chk("R7 idle counter", 64'(d), 64'd0);

        // R1 mid-run reset
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        chk("R1 regs cleared", 64'(regs_q == '0), 64'd1);
        wr(4'd3, 32'h0000_FACE);
        chk("R1 stage cleared", regs_q[127:64], 64'h0000_0000_0000_FACE);
        rd(4'd9, d, ds);  chk("R1 counter cleared", 64'(d), 64'd0);

        idle(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule